// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM Core

A single-port synchronous memory of 36-bit words split into four 9-bit byte lanes. Address, control and byte enables are captured on a rising clock edge; the word for a read appears combinationally in the cycle right after that edge (flow-through). The data of a write arrives one enabled edge later than its address. No idle cycles are needed between a write and a read.

A load cycle (`ld_n` low) starts an access at an external address. An advance cycle (`ld_n` high) steps a 2-bit burst counter that was seeded from the two low address bits, and keeps the type of the access. Three chip enables select the device, but only on load cycles. An active-low clock enable freezes every register in the block. An active-low output enable gates the read drivers without reference to the clock.

Top module: `ftsram_core`

## Requirements
- R1: After reset no access is active: `rd_drive` is 0 and `rd_data` is all zeros until a selected load occurs.
- R2: On an enabled edge with `ld_n` low and the device selected, the address is registered. `wr_n` low makes the access a write and high makes it a read. In the cycle that follows a read, `rd_data` shows the stored word at that address and `rd_drive` is 1.
- R3: The device is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1 on a load edge. A deselected load leaves the device idle: it drives no data, and the advances that follow neither drive nor write until the next selected load.
- R4: An enabled advance edge (`ld_n` high) on an active access adds 1 modulo 4 to address bits [1:0]. The upper address bits are kept (for example 6,7,4,5), and `wr_n` is ignored.
- R5: Write data is captured on the next enabled edge after the edge of its access. Lane i is bits [9i+8:9i], and it is written only when `bwe_n[i]` was 0 on the access edge.
- R6: A read issued right after a write needs no idle cycle. When the read hits the address still in the write pipeline, it returns the new data lane by lane.
- R7: While `clk_en_n` is 1, edges are ignored. All state, the read output and any pending write data capture stay as they were.
- R8: While `oe_n` is 1, `rd_drive` is 0 and `rd_data` is zero, without reference to the clock.
- R9: `bwe_n` is sampled on every access edge, both load and advance. Each beat of a burst uses its own mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| ld_n | input | 1 | Low: load new address; high: advance burst |
| wr_n | input | 1 | Low: write access, high: read (load cycles only) |
| addr | input | AW | Word address |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b_n | input | 1 | Chip enable, active low |
| sel_c | input | 1 | Chip enable, active high |
| bwe_n | input | 4 | Active-low byte-lane write enables |
| wdata | input | 36 | Write data for the previous access beat |
| oe_n | input | 1 | Active-low asynchronous output enable |
| rd_data | output | 36 | Read word, zero when not driven |
| rd_drive | output | 1 | High when the read drivers are on |

## Verification
On every cycle the assertions check several properties. A frozen cycle changes no state, and a high output enable silences the outputs. A deselected load leaves the block idle. An advance steps only the low two address bits, modulo 4, and keeps the access type. Every active write beat moves into the write pipeline with its address. Only the bench scenarios can show that the right data is returned: the flow-through timing, the lane-merged forwarding of a write still in flight, per-beat masks in a burst, and write data that is not captured during a frozen cycle. The bench compares these against its own reference array.

// File: rtl/ftsram_pkg.sv
`timescale 1ns/1ps
package ftsram_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_mask_t;

    // Registered access descriptor
    typedef struct packed {
        logic       act;
        logic       wr;
        lane_mask_t bwe_n;
    } acc_ctl_t;

    function automatic logic selected(logic a_n, logic b_n, logic c);
        return !a_n && !b_n && c;
    endfunction

    // Replace lanes of base with lanes of upd where take is set
    function automatic word_t lane_merge(word_t base, word_t upd, lane_mask_t take);
        word_t r = base;
        for (int i = 0; i < LANES; i++)
            if (take[i]) r[i*LANE_W +: LANE_W] = upd[i*LANE_W +: LANE_W];
        return r;
    endfunction
endpackage

// File: rtl/ftsram_ctrl.sv
`timescale 1ns/1ps
module ftsram_ctrl
    import ftsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cke,
    input  logic            ld_n,
    input  logic            wr_n,
    input  logic [AW-1:0]   addr,
    input  logic            sel_a_n,
    input  logic            sel_b_n,
    input  logic            sel_c,
    input  lane_mask_t      bwe_n,
    output acc_ctl_t        acc,
    output logic [AW-1:0]   eff_addr
);
    localparam int CW = 2;

    acc_ctl_t        ctl_q;
    logic [AW-1:CW]  base_q;
    logic [CW-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (cke) begin
            if (!ld_n) begin
                ctl_q.act   <= selected(sel_a_n, sel_b_n, sel_c);
                ctl_q.wr    <= selected(sel_a_n, sel_b_n, sel_c) && !wr_n;
                ctl_q.bwe_n <= bwe_n;
                base_q      <= addr[AW-1:CW];
                cnt_q       <= addr[CW-1:0];
            end else if (ctl_q.act) begin
                cnt_q       <= cnt_q + 1'b1;
                ctl_q.bwe_n <= bwe_n;
            end
        end
    end

    assign acc      = ctl_q;
    assign eff_addr = {base_q, cnt_q};
endmodule

// File: rtl/ftsram_wpipe.sv
`timescale 1ns/1ps
module ftsram_wpipe
    import ftsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cke,
    input  acc_ctl_t        acc,
    input  logic [AW-1:0]   eff_addr,
    input  word_t           wdata,
    output logic            pend_vld,
    output logic [AW-1:0]   pend_addr,
    output lane_mask_t      pend_bwe_n,
    output word_t           pend_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld   <= 1'b0;
            pend_addr  <= '0;
            pend_bwe_n <= '1;
            pend_data  <= '0;
        end else if (cke) begin
            pend_vld   <= acc.act && acc.wr;
            pend_addr  <= eff_addr;
            pend_bwe_n <= acc.bwe_n;
            pend_data  <= wdata;
        end
    end
endmodule

// File: rtl/ftsram_array.sv
`timescale 1ns/1ps
module ftsram_array
    import ftsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  lane_mask_t      wmask,
    input  word_t           wdata,
    input  logic [AW-1:0]   raddr,
    output word_t           rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_l [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wmask[g])
                mem_l[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem_l[raddr];
    end
endmodule

// File: rtl/ftsram_core.sv
`timescale 1ns/1ps
module ftsram_core
    import ftsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clk_en_n,
    input  logic            ld_n,
    input  logic            wr_n,
    input  logic [AW-1:0]   addr,
    input  logic            sel_a_n,
    input  logic            sel_b_n,
    input  logic            sel_c,
    input  logic [3:0]      bwe_n,
    input  logic [35:0]     wdata,
    input  logic            oe_n,
    output logic [35:0]     rd_data,
    output logic            rd_drive
);
    logic            cke;
    acc_ctl_t        acc;
    logic [AW-1:0]   eff_addr;
    logic            pend_vld;
    logic [AW-1:0]   pend_addr;
    lane_mask_t      pend_bwe_n;
    word_t           pend_data;
    word_t           arr_q;
    word_t           fwd_q;
    logic            hit;
    logic            acc_act;
    logic            acc_wr;

    assign cke = !clk_en_n;

    ftsram_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst(rst), .cke(cke), .ld_n(ld_n), .wr_n(wr_n),
        .addr(addr), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
        .bwe_n(bwe_n), .acc(acc), .eff_addr(eff_addr)
    );

    ftsram_wpipe #(.AW(AW)) u_wpipe (
        .clk(clk), .rst(rst), .cke(cke), .acc(acc), .eff_addr(eff_addr),
        .wdata(wdata), .pend_vld(pend_vld), .pend_addr(pend_addr),
        .pend_bwe_n(pend_bwe_n), .pend_data(pend_data)
    );

    // Pending write commits on the next enabled edge
    ftsram_array #(.AW(AW)) u_array (
        .clk(clk), .we(cke && pend_vld), .waddr(pend_addr),
        .wmask(~pend_bwe_n), .wdata(pend_data),
        .raddr(eff_addr), .rdata(arr_q)
    );

    assign hit      = pend_vld && (pend_addr == eff_addr);
    assign fwd_q    = lane_merge(arr_q, pend_data, hit ? ~pend_bwe_n : '0);
    assign acc_act  = acc.act;
    assign acc_wr   = acc.wr;
    assign rd_drive = acc.act && !acc.wr && !oe_n;
    assign rd_data  = rd_drive ? fwd_q : '0;
endmodule

// File: rtl/ftsram_chk.sv
`timescale 1ns/1ps
module ftsram_chk #(
    parameter int AW = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clk_en_n,
    input  logic            ld_n,
    input  logic            oe_n,
    input  logic            sel_a_n,
    input  logic            sel_b_n,
    input  logic            sel_c,
    input  logic            rd_drive,
    input  logic [35:0]     rd_data,
    input  logic            acc_act,
    input  logic            acc_wr,
    input  logic [AW-1:0]   eff_addr,
    input  logic            pend_vld,
    input  logic [AW-1:0]   pend_addr
);
    // R7: a frozen edge changes no state
    assert_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> $stable(acc_act) && $stable(acc_wr) && $stable(eff_addr)
                     && $stable(pend_vld) && $stable(pend_addr));

    // R8: output enable high silences the drivers
    assert_oe_gate_R8: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !rd_drive && rd_data == '0);

    // R3: deselected load leaves the block idle
    assert_deselect_R3: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !ld_n && !(!sel_a_n && !sel_b_n && sel_c)) |=> !acc_act);

    // R3: advances after an idle state stay idle
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && ld_n && !acc_act) |=> !acc_act && !pend_vld);

    // R4: advance steps low bits modulo 4, upper bits and type kept
    assert_burst_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && ld_n && acc_act) |=>
            eff_addr[1:0] == $past(eff_addr[1:0]) + 2'd1
            && eff_addr[AW-1:2] == $past(eff_addr[AW-1:2])
            && acc_wr == $past(acc_wr) && acc_act);

    // R5: each active write beat enters the write pipeline
    assert_wr_capture_R5: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && acc_act && acc_wr) |=> pend_vld && pend_addr == $past(eff_addr));
endmodule

bind ftsram_core ftsram_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .ld_n(ld_n), .oe_n(oe_n),
    .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
    .rd_drive(rd_drive), .rd_data(rd_data), .acc_act(acc_act), .acc_wr(acc_wr),
    .eff_addr(eff_addr), .pend_vld(pend_vld), .pend_addr(pend_addr)
);

// File: tb/sim_ftsram_core.sv
`timescale 1ns/1ps
module sim_ftsram_core;
    import ftsram_pkg::*;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam logic [2:0] CS_ON = 3'b001; // {sel_a_n, sel_b_n, sel_c}

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clk_en_n = 1'b0;
    logic          ld_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          sel_a_n = 1'b1;
    logic          sel_b_n = 1'b1;
    logic          sel_c = 1'b0;
    logic [3:0]    bwe_n = '1;
    logic [35:0]   wdata = '0;
    logic          oe_n = 1'b0;
    logic [35:0]   rd_data;
    logic          rd_drive;

    always #10 clk = ~clk; // 50 MHz

    ftsram_core #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .ld_n(ld_n), .wr_n(wr_n),
        .addr(addr), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
        .bwe_n(bwe_n), .wdata(wdata), .oe_n(oe_n),
        .rd_data(rd_data), .rd_drive(rd_drive)
    );

    typedef struct {
        logic  drv;
        word_t dat;
        string req;
    } exp_t;

    exp_t  q[$];
    int    n_cmp = 0;
    int    n_bad = 0;

    // Reference model state, kept from the requirements
    word_t         ref_mem [DEPTH];
    logic          m_act = 1'b0;
    logic          m_wr  = 1'b0;
    logic [3:0]    m_bwe = '1;
    logic [AW-1:0] m_eff = '0;

    function automatic word_t pat(int a, int s);
        return {4'(a), 32'(a * 32'h9E3779B1) ^ 32'(s)};
    endfunction

    task automatic check(input logic d_act, input word_t v_act,
                         input logic d_exp, input word_t v_exp, input string req);
        n_cmp++;
        if (d_act !== d_exp || v_act !== v_exp) begin
            n_bad++;
            $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
                     req, d_act, v_act, d_exp, v_exp);
        end
    endtask

    // Driver: one clock cycle of stimulus, model update, expectation push
    task automatic step(input logic l_n, input logic w_n, input int a,
                        input logic [2:0] cs, input logic [3:0] be,
                        input word_t wd, input logic ce_n, input logic o_n,
                        input string req);
        exp_t e;
        @(negedge clk);
        ld_n = l_n; wr_n = w_n; addr = AW'(a);
        {sel_a_n, sel_b_n, sel_c} = cs;
        bwe_n = be; wdata = wd; clk_en_n = ce_n; oe_n = o_n;
        @(posedge clk);
        if (!ce_n) begin
            if (m_act && m_wr)
                for (int i = 0; i < LANES; i++)
                    if (!m_bwe[i]) ref_mem[m_eff][i*LANE_W +: LANE_W] = wd[i*LANE_W +: LANE_W];
            if (!l_n) begin
                m_act = (cs == CS_ON);
                m_wr  = m_act && !w_n;
                m_eff = AW'(a);
                m_bwe = be;
            end else if (m_act) begin
                m_eff[1:0] = m_eff[1:0] + 2'd1;
                m_bwe = be;
            end
        end
        e.drv = m_act && !m_wr && !o_n;
        e.dat = e.drv ? ref_mem[m_eff] : '0;
        e.req = req;
        q.push_back(e);
    endtask

    // Monitor: compare well after each edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(rd_drive, rd_data, e.drv, e.dat, e.req);
            end
        end
    end

    logic done = 1'b0;

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle after reset
        check(rd_drive, rd_data, 1'b0, '0, "R1 reset idle");

        // R2 R4 R5: fill every word by write bursts, data one beat behind
        for (int k = 0; k < DEPTH; k++)
            step((k % 4) != 0, 1'b0, k, CS_ON, 4'b0000, pat(k - 1, 0), 1'b0, 1'b0, "R5 fill");
        step(1'b0, 1'b1, 0, CS_ON, 4'b1111, pat(DEPTH - 1, 0), 1'b0, 1'b0, "R6 read after fill");

        // R2 single reads
        step(1'b0, 1'b1, 17, CS_ON, 4'b1111, '0, 1'b0, 1'b0, "R2 read 17");
        step(1'b0, 1'b1, 42, CS_ON, 4'b1111, '0, 1'b0, 1'b0, "R2 read 42");

        // R4 wrapping read burst 6,7,4,5 with wr_n low on advances
        step(1'b0, 1'b1, 6, CS_ON, 4'b1111, '0, 1'b0, 1'b0, "R4 burst load");
        for (int k = 0; k < 3; k++)
            step(1'b1, 1'b0, 0, CS_ON, 4'b0000, pat(99, k), 1'b0, 1'b0, "R4 burst wrap, wr_n ignored");

        // R5 R6 lane write at 9 then immediate forwarded read
        step(1'b0, 1'b0, 9, CS_ON, 4'b1010, '0, 1'b0, 1'b0, "R5 lane write addr");
        step(1'b0, 1'b1, 9, CS_ON, 4'b1111, pat(9, 77), 1'b0, 1'b0, "R6 forwarded lane read");
        step(1'b0, 1'b1, 9, CS_ON, 4'b1111, '0, 1'b0, 1'b0, "R5 lane read from array");

        // R6 write then read other address, no idle
        step(1'b0, 1'b0, 20, CS_ON, 4'b0000, '0, 1'b0, 1'b0, "R6 write 20");
        step(1'b0, 1'b1, 21, CS_ON, 4'b1111, pat(20, 5), 1'b0, 1'b0, "R6 read 21 back to back");
        step(1'b0, 1'b1, 20, CS_ON, 4'b1111, '0, 1'b0, 1'b0, "R6 read 20");

        // R9 burst write with per-beat masks, then read burst
        step(1'b0, 1'b0, 33, CS_ON, 4'b1110, '0, 1'b0, 1'b0, "R9 burst write");
        step(1'b1, 1'b1, 0, CS_ON, 4'b0111, pat(33, 1), 1'b0, 1'b0, "R9 beat 2");
        step(1'b1, 1'b1, 0, CS_ON, 4'b1001, pat(34, 2), 1'b0, 1'b0, "R9 beat 3");
        step(1'b1, 1'b1, 0, CS_ON, 4'b0000, pat(35, 3), 1'b0, 1'b0, "R9 beat 4");
        step(1'b0, 1'b1, 33, CS_ON, 4'b1111, pat(32, 4), 1'b0, 1'b0, "R9 read back");
        for (int k = 0; k < 3; k++)
            step(1'b1, 1'b1, 0, CS_ON, 4'b1111, '0, 1'b0, 1'b0, "R9 read back burst");

        // R3 each chip enable alone deasserted
        step(1'b0, 1'b1, 12, 3'b101, 4'b1111, '0, 1'b0, 1'b0, "R3 sel_a_n high");
        step(1'b0, 1'b1, 12, 3'b011, 4'b1111, '0, 1'b0, 1'b0, "R3 sel_b_n high");
        step(1'b0, 1'b1, 12, 3'b000, 4'b1111, '0, 1'b0, 1'b0, "R3 sel_c low");
        step(1'b0, 1'b0, 12, 3'b000, 4'b0000, '0, 1'b0, 1'b0, "R3 deselected write");
        for (int k = 0; k < 3; k++)
            step(1'b1, 1'b0, 0, CS_ON, 4'b0000, pat(500, k), 1'b0, 1'b0, "R3 idle advance");
        step(1'b0, 1'b1, 12, CS_ON, 4'b1111, pat(600, 0), 1'b0, 1'b0, "R3 memory untouched");
        step(1'b0, 1'b1, 13, CS_ON, 4'b1111, '0, 1'b0, 1'b0, "R3 memory untouched 13");

        // R7 freeze during a read and between write address and data
        step(1'b0, 1'b1, 50, CS_ON, 4'b1111, '0, 1'b0, 1'b0, "R7 read 50");
        step(1'b0, 1'b0, 3, CS_ON, 4'b0000, '0, 1'b1, 1'b0, "R7 frozen load");
        step(1'b0, 1'b0, 51, CS_ON, 4'b0000, '0, 1'b0, 1'b0, "R7 write 51");
        step(1'b0, 1'b1, 2, CS_ON, 4'b1111, pat(700, 0), 1'b1, 1'b0, "R7 frozen data beat");
        step(1'b0, 1'b1, 2, CS_ON, 4'b1111, pat(51, 9), 1'b0, 1'b0, "R7 real data beat");
        step(1'b0, 1'b1, 51, CS_ON, 4'b1111, '0, 1'b0, 1'b0, "R7 read 51");

        // R8 output enable gating
        step(1'b0, 1'b1, 40, CS_ON, 4'b1111, '0, 1'b0, 1'b1, "R8 oe_n high on read");
        step(1'b1, 1'b1, 0, CS_ON, 4'b1111, '0, 1'b0, 1'b0, "R8 oe_n low again");

        step(1'b0, 1'b1, 0, 3'b000, 4'b1111, '0, 1'b0, 1'b0, "R3 final idle");
        repeat (3) @(posedge clk);
        #6;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL monitor: %0d items left, expected 0", q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule